// File: doc/BRIEF.md
# Indexed PCI Interrupt Routing Multiplexer

This block steers the active-low interrupt lines of several PCI slots (four lines per slot, pins A to D) onto a vector of sixteen legacy interrupt request outputs. Each slot line has its own 4-bit routing code. The code either names the output the line drives or leaves the line disconnected. All lines that are steered to one output share it: the output is asserted while any of those lines is asserted. The block also holds a trigger-mode nibble for ten of the outputs and presents a per-output level/edge vector to the downstream interrupt controllers.

Software reaches every nibble through one index/data pair on a byte-wide I/O bus. A write to the index port selects an internal byte. Reads and writes on the data port then access that byte. Routing bytes hold two slot lines each, with the lower-lettered pin in the low nibble. Trigger bytes hold two outputs each, with the lower-numbered output in the low nibble.

Top module: `irq_route_mux`

## Requirements
- R1: A write on I/O address 0x00EA loads the index byte. A read on 0x00EA returns the index byte. Writes to any address other than 0x00EA and 0x00EB change nothing.
- R2: Index byte 2*s+h (h = 0 or 1) is the routing byte of slot position s. Its low nibble holds pin 2*h and its high nibble holds pin 2*h+1, where pin 0 is A. Slot line number 4*s+p is bit 4*s+p of `slot_int_n`. The byte reads back through 0x00EB exactly as written.
- R3: Routing codes 0, 1 and 2 leave a line disconnected, so that line asserts no output. All routing bytes reset to 22h. Outputs 0 to 2 are never asserted.
- R4: A line with a routing code n of 3 or more, held low, asserts bit n of `irq_o` one clock after the line is sampled low. The bit deasserts one clock after the line is sampled high.
- R5: Lines that share one output are combined as a logical OR. The output stays high until every line steered to it is high.
- R6: Trigger bytes at indexes 10h to 14h cover the output pairs (3,4), (5,7), (9,10), (11,12) and (14,15), with the low nibble for the lower output. They reset to 43h, 75h, A9h, CBh and FEh. After reset `irq_level_o` is all zero, which means edge mode everywhere.
- R7: A trigger nibble of 2h sets that output's `irq_level_o` bit to 1 (level). Writing the output's own number clears the bit (edge). The change is visible in the cycle after the data-port write.
- R8: Outputs 0, 1, 2, 6, 8 and 13 have no trigger nibble, and their `irq_level_o` bits are always 0.
- R9: Indexes that are neither routing bytes of a present slot nor 10h to 14h read as 00h. Writes to them alter no routing, trigger or output state.
- R10: Read data appears on `io_rdata` in the cycle after a read strobe on 0x00EA or 0x00EB. It holds its value until the next such read. A read strobe on any other address leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | I/O bus address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Registered read data byte |
| slot_int_n | input | 4*NUM_SLOTS | Active-low slot interrupt lines, line 4*s+p is slot position s, pin p |
| irq_o | output | 16 | Active-high combined interrupt request outputs |
| irq_level_o | output | 16 | Per-output trigger mode, 1 = level, 0 = edge |

## Verification
A corrupted routing nibble shows up at the ports in two ways. The byte reads back wrong on the data port in the cycle after the read. An asserted slot line lights the wrong `irq_o` bit, or no bit, one clock after it goes low. A stuck or mis-decoded trigger nibble changes `irq_level_o` in the cycle after the offending write, and a bad reset value shows there at once. A wrong index register steers every later data access to the wrong byte, so the next data-port read exposes it.

// File: rtl/irq_route_mux_pkg.sv
package irq_route_mux_pkg;

    localparam logic [15:0] IDX_PORT_ADDR = 16'h00EA;
    localparam logic [15:0] DAT_PORT_ADDR = 16'h00EB;

    localparam int          NUM_TRIG_BYTES = 5;
    localparam int          NUM_TRIG_NIBS  = 2 * NUM_TRIG_BYTES;
    localparam logic [7:0]  TRIG_BASE_IDX  = 8'h10;
    localparam logic [3:0]  CODE_LAST_OFF  = 4'h2;   // codes 0..2 disconnect
    localparam logic [3:0]  NIB_LEVEL      = 4'h2;

    // Output served by trigger nibble j (low nibble of byte j/2 is even j)
    function automatic logic [3:0] trig_out(input int j);
        case (j)
            0: trig_out = 4'd3;
            1: trig_out = 4'd4;
            2: trig_out = 4'd5;
            3: trig_out = 4'd7;
            4: trig_out = 4'd9;
            5: trig_out = 4'd10;
            6: trig_out = 4'd11;
            7: trig_out = 4'd12;
            8: trig_out = 4'd14;
            default: trig_out = 4'd15;
        endcase
    endfunction

    // Reset image of the trigger bytes: each nibble equals its own output number
    function automatic logic [NUM_TRIG_BYTES*8-1:0] trig_reset_image();
        logic [NUM_TRIG_BYTES*8-1:0] v;
        v = '0;
        for (int j = 0; j < NUM_TRIG_NIBS; j++) begin
            v[j*4 +: 4] = trig_out(j);
        end
        return v;
    endfunction

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_mux_pkg::*;
#(
    parameter int NUM_LINES = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [15:0]                 io_addr,
    input  logic                        io_wr,
    input  logic                        io_rd,
    input  logic [7:0]                  io_wdata,
    output logic [7:0]                  io_rdata,
    output logic [NUM_LINES*4-1:0]      route_o,
    output logic [NUM_TRIG_BYTES*8-1:0] trig_o
);

    localparam int NUM_RBYTES = NUM_LINES / 2;
    localparam logic [NUM_LINES*4-1:0]      ROUTE_RST = {NUM_LINES{CODE_LAST_OFF}};
    localparam logic [NUM_TRIG_BYTES*8-1:0] TRIG_RST  = trig_reset_image();

    typedef struct packed {
        logic [7:0]                  idx;
        logic [7:0]                  rdata;
        logic [NUM_LINES*4-1:0]      route;
        logic [NUM_TRIG_BYTES*8-1:0] trig;
    } regs_t;

    regs_t st_d, st_q;

    logic       sel_idx, sel_dat;
    logic       hit_route, hit_trig;
    int         rbyte, tbyte;
    logic [7:0] dat_byte;

    always_comb begin
        st_d      = st_q;
        sel_idx   = (io_addr == IDX_PORT_ADDR);
        sel_dat   = (io_addr == DAT_PORT_ADDR);
        rbyte     = int'(st_q.idx);
        tbyte     = int'(st_q.idx) - int'(TRIG_BASE_IDX);
        hit_route = (rbyte < NUM_RBYTES);
        hit_trig  = (st_q.idx >= TRIG_BASE_IDX) && (tbyte < NUM_TRIG_BYTES);

        dat_byte = 8'h00;
        if (hit_route) begin
            dat_byte = st_q.route[rbyte*8 +: 8];
        end else if (hit_trig) begin
            dat_byte = st_q.trig[tbyte*8 +: 8];
        end

        if (io_rd && sel_idx) begin
            st_d.rdata = st_q.idx;
        end else if (io_rd && sel_dat) begin
            st_d.rdata = dat_byte;
        end

        if (io_wr && sel_idx) begin
            st_d.idx = io_wdata;
        end else if (io_wr && sel_dat) begin
            if (hit_route) begin
                st_d.route[rbyte*8 +: 8] = io_wdata;
            end else if (hit_trig) begin
                st_d.trig[tbyte*8 +: 8] = io_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.idx   <= 8'h00;
            st_q.rdata <= 8'h00;
            st_q.route <= ROUTE_RST;
            st_q.trig  <= TRIG_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign io_rdata = st_q.rdata;
    assign route_o  = st_q.route;
    assign trig_o   = st_q.trig;

endmodule

// File: rtl/irq_route_fabric.sv
module irq_route_fabric
    import irq_route_mux_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int NUM_OUTS  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_LINES*4-1:0] route_i,
    input  logic [NUM_LINES-1:0]   line_n_i,
    output logic [NUM_OUTS-1:0]    irq_o
);

    localparam int FIRST_OUT = int'(CODE_LAST_OFF) + 1;

    logic [NUM_LINES-1:0] hit [NUM_OUTS];
    logic [NUM_OUTS-1:0]  irq_d, irq_q;

    // One OR tree per output; outputs below FIRST_OUT have no codes reaching them
    for (genvar k = 0; k < NUM_OUTS; k++) begin : g_out
        for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
            if (k >= FIRST_OUT) begin : g_live
                assign hit[k][l] = !line_n_i[l] && (route_i[l*4 +: 4] == 4'(k));
            end else begin : g_dead
                assign hit[k][l] = 1'b0;
            end
        end
    end

    always_comb begin
        for (int k = 0; k < NUM_OUTS; k++) begin
            irq_d[k] = |hit[k];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/irq_route_mode.sv
module irq_route_mode
    import irq_route_mux_pkg::*;
#(
    parameter int NUM_OUTS = 16
) (
    input  logic [NUM_TRIG_BYTES*8-1:0] trig_i,
    output logic [NUM_OUTS-1:0]         level_o
);

    always_comb begin
        level_o = '0;
        for (int j = 0; j < NUM_TRIG_NIBS; j++) begin
            level_o[trig_out(j)] = (trig_i[j*4 +: 4] == NIB_LEVEL);
        end
    end

endmodule

// File: rtl/irq_route_mux.sv
module irq_route_mux
    import irq_route_mux_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [15:0]            io_addr,
    input  logic                   io_wr,
    input  logic                   io_rd,
    input  logic [7:0]             io_wdata,
    output logic [7:0]             io_rdata,
    input  logic [NUM_SLOTS*4-1:0] slot_int_n,
    output logic [15:0]            irq_o,
    output logic [15:0]            irq_level_o
);

    localparam int NUM_LINES = NUM_SLOTS * 4;
    localparam int NUM_OUTS  = 16;

    logic [NUM_LINES*4-1:0]      route;
    logic [NUM_TRIG_BYTES*8-1:0] trig;

    irq_route_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .route_o  (route),
        .trig_o   (trig)
    );

    irq_route_fabric #(.NUM_LINES(NUM_LINES), .NUM_OUTS(NUM_OUTS)) u_fabric (
        .clk      (clk),
        .rst_n    (rst_n),
        .route_i  (route),
        .line_n_i (slot_int_n),
        .irq_o    (irq_o)
    );

    irq_route_mode #(.NUM_OUTS(NUM_OUTS)) u_mode (
        .trig_i  (trig),
        .level_o (irq_level_o)
    );

endmodule

// File: rtl/irq_route_mux_checker.sv
module irq_route_mux_checker
    import irq_route_mux_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [15:0]            io_addr,
    input logic                   io_wr,
    input logic                   io_rd,
    input logic [7:0]             io_rdata,
    input logic [NUM_SLOTS*4-1:0] slot_int_n,
    input logic [15:0]            irq_o,
    input logic [15:0]            irq_level_o
);

    localparam logic [15:0] NO_NIB_MASK = 16'h2147;   // outputs 0,1,2,6,8,13

    logic port_rd, dat_wr;
    assign port_rd = io_rd && ((io_addr == IDX_PORT_ADDR) || (io_addr == DAT_PORT_ADDR));
    assign dat_wr  = io_wr && (io_addr == DAT_PORT_ADDR);

    a_r3_low_outputs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[2:0] == 3'b000);

    a_r4_no_lines_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (&slot_int_n) |=> (irq_o == 16'h0000));

    a_r7_mode_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !dat_wr |=> $stable(irq_level_o));

    a_r8_fixed_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level_o & NO_NIB_MASK) == 16'h0000);

    a_r10_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !port_rd |=> $stable(io_rdata));

endmodule

bind irq_route_mux irq_route_mux_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_addr     (io_addr),
    .io_wr       (io_wr),
    .io_rd       (io_rd),
    .io_rdata    (io_rdata),
    .slot_int_n  (slot_int_n),
    .irq_o       (irq_o),
    .irq_level_o (irq_level_o)
);

// File: tb/irq_route_mux_tb.sv
module irq_route_mux_tb;

    localparam int NS = 4;
    localparam int NL = NS * 4;
    localparam logic [15:0] A_IDX = 16'h00EA;
    localparam logic [15:0] A_DAT = 16'h00EB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   io_addr = '0;
    logic          io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]    io_wdata = '0;
    logic [7:0]    io_rdata;
    logic [NL-1:0] slot_int_n = '1;
    logic [15:0]   irq_o, irq_level_o;

    always #4 clk = ~clk;   // 125 MHz

    irq_route_mux #(.NUM_SLOTS(NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .slot_int_n(slot_int_n),
        .irq_o(irq_o), .irq_level_o(irq_level_o)
    );

    typedef struct {
        int          due;
        int          kind;   // 0 rdata, 1 irq, 2 level
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int    cyc = 0;
    int    n_cmp = 0, n_bad = 0;
    bit    done = 0;

    // reference model, built from the requirements
    logic [3:0] m_route [NL];
    logic [7:0] m_trig  [5];
    logic [7:0] m_idx, m_rdata;
    logic [NL-1:0] m_slots;
    int tnib_out [10] = '{3, 4, 5, 7, 9, 10, 11, 12, 14, 15};

    function automatic logic [15:0] exp_irq();
        logic [15:0] v = '0;
        for (int l = 0; l < NL; l++)
            if (!m_slots[l] && m_route[l] >= 4'd3) v[m_route[l]] = 1'b1;
        return v;
    endfunction

    function automatic logic [15:0] exp_level();
        logic [15:0] v = '0;
        for (int j = 0; j < 10; j++)
            if (m_trig[j/2][(j%2)*4 +: 4] == 4'h2) v[tnib_out[j]] = 1'b1;
        return v;
    endfunction

    function automatic logic [7:0] exp_dat();
        if (int'(m_idx) < NL / 2) return {m_route[2*m_idx+1], m_route[2*m_idx]};
        if (m_idx >= 8'h10 && m_idx <= 8'h14) return m_trig[m_idx - 8'h10];
        return 8'h00;
    endfunction

    task automatic push(int kind, logic [15:0] exp, string tag);
        item_t it;
        it.due = cyc + 1; it.kind = kind; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare every item whose result is due
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            item_t it;
            logic [15:0] act;
            it = sb_q.pop_front();
            act = (it.kind == 0) ? {8'h00, io_rdata} : (it.kind == 1) ? irq_o : irq_level_o;
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    task automatic io_write(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        if (a == A_IDX) m_idx = d;
        else if (a == A_DAT) begin
            if (int'(m_idx) < NL / 2) begin
                m_route[2*m_idx]   = d[3:0];
                m_route[2*m_idx+1] = d[7:4];
            end else if (m_idx >= 8'h10 && m_idx <= 8'h14) m_trig[m_idx - 8'h10] = d;
        end
        @(posedge clk); #1 io_wr = 1'b0;
    endtask

    task automatic io_read(logic [15:0] a, string tag);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        if (a == A_IDX) m_rdata = m_idx;
        else if (a == A_DAT) m_rdata = exp_dat();
        push(0, {8'h00, m_rdata}, tag);
        @(posedge clk); #1 io_rd = 1'b0;
    endtask

    task automatic rd_idx(logic [7:0] i, string tag);
        io_write(A_IDX, i);
        io_read(A_DAT, tag);
    endtask

    task automatic wr_idx(logic [7:0] i, logic [7:0] d);
        io_write(A_IDX, i);
        io_write(A_DAT, d);
    endtask

    task automatic set_lines(logic [NL-1:0] v, string tag);
        @(negedge clk);
        slot_int_n = v; m_slots = v;
        push(1, exp_irq(), tag);
        @(posedge clk); #1;
    endtask

    task automatic chk_level(string tag);
        @(negedge clk);
        push(2, exp_level(), tag);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int l = 0; l < NL; l++) m_route[l] = 4'h2;
        m_trig = '{8'h43, 8'h75, 8'hA9, 8'hCB, 8'hFE};
        m_idx = 8'h00; m_rdata = 8'h00; m_slots = '1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state (R6, R3)
        @(negedge clk);
        n_cmp += 3;
        if (io_rdata !== 8'h00) begin n_bad++; $display("FAIL R10 reset rdata actual=%h expected=00", io_rdata); end
        if (irq_o !== 16'h0) begin n_bad++; $display("FAIL R3 reset irq actual=%h expected=0000", irq_o); end
        if (irq_level_o !== 16'h0) begin n_bad++; $display("FAIL R6 reset level actual=%h expected=0000", irq_level_o); end

        for (int i = 0; i < 5; i++) rd_idx(8'h10 + 8'(i), "R6 trigger reset byte");
        for (int i = 0; i < NL / 2; i++) rd_idx(8'(i), "R3 routing reset 22h");
        set_lines('0, "R3 all lines low after reset");
        set_lines('1, "R3 release");

        // index port (R1)
        io_write(A_IDX, 8'h5A);
        io_read(A_IDX, "R1 index readback");
        io_write(16'h00EC, 8'h11);
        io_read(A_IDX, "R1 foreign address write ignored");

        // routing (R2, R4)
        wr_idx(8'h00, 8'h5B);
        io_read(A_DAT, "R2 routing readback");
        set_lines(16'hFFFE, "R4 slot0 pin A to 11");
        set_lines(16'hFFFC, "R4 slot0 pins A,B to 11,5");
        set_lines(16'hFFFF, "R4 release");
        wr_idx(8'h07, 8'hF3);
        set_lines(16'h7FFF, "R2 slot3 pin D to 15");
        set_lines(16'hBFFF, "R2 slot3 pin C to 3");

        // sharing (R5)
        wr_idx(8'h02, 8'hBB);
        set_lines(16'hFFCE, "R5 three lines on 11");
        set_lines(16'hFFCF, "R5 one released");
        set_lines(16'hFFEF, "R5 one left");
        set_lines(16'hFFFF, "R5 all released");

        // disconnect codes (R3)
        wr_idx(8'h01, 8'h10);
        wr_idx(8'h03, 8'h22);
        set_lines(16'hFFF3, "R3 codes 0 1 disconnect");
        set_lines(16'hFF0F, "R3 code 2 disconnect");

        // trigger mode (R7, R8)
        wr_idx(8'h11, 8'h72);
        chk_level("R7 output 5 level");
        wr_idx(8'h14, 8'h22);
        chk_level("R7 outputs 14 15 level");
        wr_idx(8'h10, 8'h22);
        wr_idx(8'h12, 8'h22);
        wr_idx(8'h13, 8'h22);
        chk_level("R8 all nibbles level, fixed bits edge");
        wr_idx(8'h14, 8'hFE);
        chk_level("R7 back to edge");
        io_read(A_DAT, "R7 trigger readback");

        // unimplemented indexes (R9)
        wr_idx(8'h08, 8'h33);
        io_read(A_DAT, "R9 index 08 reads 00");
        wr_idx(8'h20, 8'hFF);
        io_read(A_DAT, "R9 index 20 reads 00");
        wr_idx(8'h0F, 8'h44);
        chk_level("R9 trigger unchanged");
        set_lines('0, "R9 routing unchanged");
        rd_idx(8'h00, "R9 routing byte 0 intact");

        // read path (R10)
        io_read(A_IDX, "R10 index read");
        io_read(16'h0080, "R10 foreign read holds");
        set_lines('1, "R10 idle");

        repeat (4) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule